// File: doc/BRIEF.md
# Programmed-IO SCSI Data Port Bridge

This block sits between a host CPU bus and a SCSI controller core on an expansion board. The host moves every byte of a SCSI data phase itself, one bus access per byte, through a small byte-wide window in the board's I/O space. There is no DMA engine. The block decodes the I/O space and forwards the controller's own registers. It holds a control byte and a status byte. It counts the bytes of the current transfer and sends the controller core a one-cycle completion pulse when the last byte has moved.

The controller core opens a transfer with a start strobe that carries a byte count and a direction.

- **Device-to-host transfers.** The core offers bytes on a valid/ready input stream. Back-pressure: a host read of the window takes a byte only while `in_valid` is high. `in_ready` shows that the block is willing to take one. A read that finds `in_valid` low returns 0 and does not advance the count.
- **Host-to-device transfers.** Each host write of the window presents its byte on an output stream. The byte counts as moved only when the core has `out_ready` high in that cycle. A write that finds `out_ready` low is dropped, and the host must repeat it.

All host accesses are single-cycle. Read data is combinational while `host_req` is high, and side effects take place at the clock edge that ends the access.

Top module: `pio_scsi_bridge`

## Requirements
- R1: An access has an effect or returns data only when `host_addr` bit 16 is set (I/O space, offsets 0x0000-0xFFFF). An access with bit 16 clear reads 0 and changes nothing.
- R2: Even I/O offsets 0x00-0x1E select a controller register. `chip_sel` is high, `chip_idx` is offset bits [4:1], write data and direction are passed through, and a read returns `chip_rdata`. Odd offsets below 0x20 select nothing and read 0.
- R3: A host write to offset 0x40 stores the byte on `ctrl_byte` and raises `dma_enable`. `dma_enable` stays high until reset.
- R4: A host read of offset 0x40 returns the status byte. Bit 6 is set when `chip_irq` is high or the board interrupt flag is set. Bit 7 is set while transfer bytes remain. All other bits are 0. `host_irq` equals bit 6.
- R5: A `board_irq_set` pulse sets the board interrupt flag. A status read clears it. When a set pulse and a status read fall in the same cycle, the flag stays set.
- R6: A `xfer_start` strobe loads the size from `xfer_len` and the direction from `xfer_dir` (1 = device-to-host, 0 = host-to-device), and clears the byte offset. It overrides an access in the same cycle and restarts any transfer in progress. A size of 0 leaves no bytes remaining and produces no completion pulse.
- R7: When the direction is 1 and bytes remain, a host read of offsets 0x20-0x27 raises `in_ready`. If `in_valid` is high, the read returns `in_data` and advances the offset by one. If `in_valid` is low, the read returns 0 and the offset does not move.
- R8: When the direction is 0 and bytes remain, a host write of offsets 0x20-0x27 raises `out_valid` with `out_data` equal to the written byte. The offset advances only if `out_ready` is high.
- R9: `xfer_done` is high for exactly one cycle: the cycle after the access that moved the last byte. It is raised once per transfer.
- R10: Once no bytes remain, a window read returns 0 with `in_ready` low, and a window write leaves `out_valid` low.
- R11: Unused I/O offsets (for example 0x30 and 0x41), and window accesses in the direction opposite to the transfer, read 0 and change nothing.
- R12: Reset clears the offset, the size, the board interrupt flag, `ctrl_byte` and `dma_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access in this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Board-relative byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| chip_sel | output | 1 | Controller register access |
| chip_we | output | 1 | Controller register write |
| chip_idx | output | 4 | Controller register index |
| chip_wdata | output | 8 | Controller register write data |
| chip_rdata | input | 8 | Controller register read data |
| chip_irq | input | 1 | Controller interrupt level |
| board_irq_set | input | 1 | Pulse that sets the board interrupt flag |
| host_irq | output | 1 | Combined interrupt to host |
| dma_enable | output | 1 | Data-phase enable to controller core |
| ctrl_byte | output | 8 | Last control byte written |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_dir | input | 1 | 1 = device-to-host, 0 = host-to-device |
| xfer_len | input | 16 | Transfer size in bytes |
| xfer_done | output | 1 | One-cycle completion pulse |
| in_valid | input | 1 | Device-to-host byte available |
| in_ready | output | 1 | Block takes device-to-host byte |
| in_data | input | 8 | Device-to-host byte |
| out_valid | output | 1 | Host-to-device byte presented |
| out_ready | input | 1 | Core accepts host-to-device byte |
| out_data | output | 8 | Host-to-device byte |

## Verification
The transfer function is tested with three-byte device-to-host reads spread over different window addresses, and with a stalled read while `in_valid` is low. These show whether any window address advances the count and whether a starved read is wrongly counted. Host-to-device writes are tested once with `out_ready` low and then with it high, which shows that a dropped byte is not counted and that the completion pulse follows the true last byte. Zero-length starts, restarts in mid-transfer, accesses past the end and accesses in the wrong direction show that the pulse fires once and that idle accesses are harmless. Status reads with the board flag and the chip interrupt set in turn, and with a set pulse colliding with a read, show which source the clear acts on.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int HOST_AW   = 17;
  localparam int DATA_W    = 8;
  localparam int LEN_W     = 16;
  localparam int CHIP_REGS = 16;
  localparam int IDX_W     = $clog2(CHIP_REGS);

  localparam logic [15:0] OFS_STATUS = 16'h0040;
  localparam logic [15:0] OFS_WIN    = 16'h0020;
  localparam int          WIN_LSB    = 3;          // window spans 2**WIN_LSB bytes
  localparam int          STAT_IRQ   = 6;
  localparam int          STAT_PEND  = 7;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CHIP = 2'd1,
    RG_STAT = 2'd2,
    RG_WIN  = 2'd3
  } region_e;
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
  import pio_pkg::*;
#(
  parameter int AW = HOST_AW,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic [IW-1:0] idx
);
  localparam int CHIP_SPAN = 2 * (1 << IW);

  logic [15:0] ofs;
  logic        in_io;

  assign ofs   = addr[15:0];
  assign in_io = req && addr[16];
  assign idx   = ofs[IW:1];

  always_comb begin
    region = RG_NONE;
    if (in_io) begin
      if (ofs < 16'(CHIP_SPAN) && !ofs[0])
        region = RG_CHIP;
      else if (ofs == OFS_STATUS)
        region = RG_STAT;
      else if (ofs[15:WIN_LSB] == OFS_WIN[15:WIN_LSB])
        region = RG_WIN;
    end
  end

  p_outside_io_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || !addr[16]) |-> region == RG_NONE);
  p_odd_chip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_CHIP) |-> !addr[0]);
endmodule

// File: rtl/pio_xfer_ctrl.sv
module pio_xfer_ctrl
  import pio_pkg::*;
#(
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_in,
  input  logic [LW-1:0] len,
  input  logic          win_rd,
  input  logic          win_wr,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          pending,
  output logic          done
);
  logic [LW-1:0] off_q, size_q;
  logic          dir_q, done_q;
  logic          adv;

  assign pending   = off_q < size_q;
  assign in_ready  = win_rd && dir_q && pending;
  assign out_valid = win_wr && !dir_q && pending;
  assign adv       = (in_ready && in_valid) || (out_valid && out_ready);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      size_q <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      off_q  <= '0;
      size_q <= len;
      dir_q  <= dir_in;
      done_q <= 1'b0;
    end else begin
      done_q <= adv && (off_q + 1'b1 == size_q);
      if (adv) off_q <= off_q + 1'b1;
    end
  end

  p_off_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= size_q);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (off_q == size_q));
  p_idle_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !start) |=> $stable(off_q));
endmodule

// File: rtl/pio_status_unit.sv
module pio_status_unit
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_set,
  input  logic              stat_rd,
  input  logic              chip_irq,
  input  logic              pending,
  output logic              irq_any,
  output logic [DATA_W-1:0] status
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (irq_set) flag_q <= 1'b1;
    else if (stat_rd) flag_q <= 1'b0;
  end

  assign irq_any = chip_irq || flag_q;

  always_comb begin
    status            = '0;
    status[STAT_IRQ]  = irq_any;
    status[STAT_PEND] = pending;
  end

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_set) |=> !flag_q);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> flag_q);
endmodule

// File: rtl/pio_scsi_bridge.sv
module pio_scsi_bridge
  import pio_pkg::*;
#(
  parameter int AW = HOST_AW,
  parameter int DW = DATA_W,
  parameter int LW = LEN_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          chip_sel,
  output logic          chip_we,
  output logic [IW-1:0] chip_idx,
  output logic [DW-1:0] chip_wdata,
  input  logic [DW-1:0] chip_rdata,
  input  logic          chip_irq,
  input  logic          board_irq_set,
  output logic          host_irq,
  output logic          dma_enable,
  output logic [DW-1:0] ctrl_byte,
  input  logic          xfer_start,
  input  logic          xfer_dir,
  input  logic [LW-1:0] xfer_len,
  output logic          xfer_done,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  region_e       region;
  logic [IW-1:0] idx;
  logic          pending;
  logic [7:0]    status;
  logic          stat_rd, stat_wr, win_rd, win_wr;
  logic          dma_q;
  logic [DW-1:0] ctrl_q;

  pio_addr_decode #(.AW(AW), .IW(IW)) u_dec (
    .clk(clk), .rst_n(rst_n), .req(host_req), .addr(host_addr),
    .region(region), .idx(idx)
  );

  assign stat_rd = (region == RG_STAT) && !host_we;
  assign stat_wr = (region == RG_STAT) && host_we;
  assign win_rd  = (region == RG_WIN) && !host_we;
  assign win_wr  = (region == RG_WIN) && host_we;

  pio_xfer_ctrl #(.LW(LW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .dir_in(xfer_dir),
    .len(xfer_len), .win_rd(win_rd), .win_wr(win_wr),
    .in_valid(in_valid), .out_ready(out_ready), .in_ready(in_ready),
    .out_valid(out_valid), .pending(pending), .done(xfer_done)
  );

  pio_status_unit u_stat (
    .clk(clk), .rst_n(rst_n), .irq_set(board_irq_set), .stat_rd(stat_rd),
    .chip_irq(chip_irq), .pending(pending), .irq_any(host_irq),
    .status(status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_q  <= 1'b0;
      ctrl_q <= '0;
    end else if (stat_wr) begin
      dma_q  <= 1'b1;
      ctrl_q <= host_wdata;
    end
  end

  assign dma_enable = dma_q;
  assign ctrl_byte  = ctrl_q;
  assign chip_sel   = (region == RG_CHIP);
  assign chip_we    = chip_sel && host_we;
  assign chip_idx   = idx;
  assign chip_wdata = host_wdata;
  assign out_data   = host_wdata;

  always_comb begin
    host_rdata = '0;
    if (!host_we) begin
      case (region)
        RG_CHIP: host_rdata = chip_rdata;
        RG_STAT: host_rdata = status;
        RG_WIN:  host_rdata = (in_ready && in_valid) ? in_data : '0;
        default: host_rdata = '0;
      endcase
    end
  end

  p_dma_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_enable |=> dma_enable);
  p_ready_needs_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> pending);
  p_streams_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

// File: tb/test_pio_scsi_bridge.sv
module test_pio_scsi_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [16:0] host_addr = '0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic        chip_sel, chip_we;
  logic [3:0]  chip_idx;
  logic [7:0]  chip_wdata, chip_rdata = '0;
  logic        chip_irq = 1'b0, board_irq_set = 1'b0, host_irq, dma_enable;
  logic [7:0]  ctrl_byte;
  logic        xfer_start = 1'b0, xfer_dir = 1'b0, xfer_done;
  logic [15:0] xfer_len = '0;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [7:0]  in_data = '0, out_data;

  int total = 0, bad = 0;
  logic [7:0] s_rd;
  logic s_inr, s_outv, s_sel, s_we, s_done, s_done2;
  logic [3:0] s_idx;
  logic [7:0] s_odata, s_cwd;

  always #4 clk = ~clk;

  pio_scsi_bridge i_pio_scsi_bridge (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one host access; samples combinational outputs mid-cycle, done after edge
  task automatic acc(input logic we, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    #2;
    s_rd = host_rdata; s_inr = in_ready; s_outv = out_valid;
    s_sel = chip_sel; s_we = chip_we; s_idx = chip_idx;
    s_odata = out_data; s_cwd = chip_wdata;
    @(posedge clk); #1;
    s_done = xfer_done;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    @(posedge clk); #1;
    s_done2 = xfer_done;
  endtask

  task automatic start(input logic dir, input logic [15:0] n);
    @(negedge clk);
    xfer_start = 1'b1; xfer_dir = dir; xfer_len = n;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 dma_enable", dma_enable, 0);
    chk("R12 ctrl_byte", ctrl_byte, 0);
    chk("R12 done", xfer_done, 0);
    acc(0, 17'h10040, 0);
    chk("R12 status", s_rd, 8'h00);
  endtask

  task automatic t_decode;
    chip_irq = 1'b1;
    acc(0, 17'h10040, 0);  chk("R4 chip irq bit", s_rd, 8'h40);
    acc(0, 17'h00040, 0);  chk("R1 below io", s_rd, 8'h00);
    acc(1, 17'h00040, 8'h77); chk("R1 write below io", ctrl_byte, 0);
    acc(0, 17'h10030, 0);  chk("R11 ofs 30", s_rd, 0);
    acc(0, 17'h10041, 0);  chk("R11 ofs 41", s_rd, 0);
    chip_irq = 1'b0;
  endtask

  task automatic t_chip;
    chip_rdata = 8'hA5;
    acc(0, 17'h1000A, 0);
    chk("R2 rdata", s_rd, 8'hA5); chk("R2 sel", s_sel, 1); chk("R2 idx", s_idx, 5);
    acc(0, 17'h1000B, 0);
    chk("R2 odd rdata", s_rd, 0); chk("R2 odd sel", s_sel, 0);
    acc(1, 17'h1001E, 8'h3C);
    chk("R2 we", s_we, 1); chk("R2 idx15", s_idx, 15); chk("R2 wdata", s_cwd, 8'h3C);
  endtask

  task automatic t_ctrl;
    acc(1, 17'h10040, 8'h5A);
    chk("R3 ctrl_byte", ctrl_byte, 8'h5A);
    chk("R3 dma_enable", dma_enable, 1);
  endtask

  task automatic t_irq;
    @(negedge clk); board_irq_set = 1'b1; @(negedge clk); board_irq_set = 1'b0;
    chk("R4 host_irq", host_irq, 1);
    acc(0, 17'h10040, 0); chk("R4 board bit", s_rd, 8'h40);
    acc(0, 17'h10040, 0); chk("R5 cleared", s_rd, 8'h00);
    chip_irq = 1'b1;
    acc(0, 17'h10040, 0); acc(0, 17'h10040, 0); chk("R5 chip not cleared", s_rd, 8'h40);
    chip_irq = 1'b0;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 17'h10040; board_irq_set = 1'b1;
    @(negedge clk);
    host_req = 1'b0; board_irq_set = 1'b0;
    acc(0, 17'h10040, 0); chk("R5 set wins", s_rd, 8'h40);
    acc(0, 17'h10040, 0); chk("R5 clear after", s_rd, 8'h00);
  endtask

  task automatic t_read_xfer;
    start(1, 3);
    acc(0, 17'h10040, 0); chk("R6 pending", s_rd, 8'h80);
    in_valid = 1'b0;
    acc(0, 17'h10020, 0);
    chk("R7 starved data", s_rd, 0); chk("R7 starved ready", s_inr, 1);
    in_valid = 1'b1;
    in_data = 8'h11; acc(0, 17'h10020, 0);
    chk("R7 byte0", s_rd, 8'h11); chk("R9 no early done", s_done, 0);
    in_data = 8'h22; acc(0, 17'h10027, 0);
    chk("R7 byte1", s_rd, 8'h22); chk("R9 no early done", s_done, 0);
    in_data = 8'h33; acc(0, 17'h10023, 0);
    chk("R7 byte2", s_rd, 8'h33);
    chk("R9 done pulse", s_done, 1); chk("R9 done one cycle", s_done2, 0);
    acc(0, 17'h10040, 0); chk("R4 no pending", s_rd, 8'h00);
    acc(0, 17'h10021, 0);
    chk("R10 read after end", s_rd, 0); chk("R10 no ready", s_inr, 0);
    chk("R9 no second done", s_done, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_write_xfer;
    start(0, 2);
    acc(0, 17'h10020, 0);
    chk("R11 wrong dir read", s_rd, 0); chk("R11 wrong dir ready", s_inr, 0);
    out_ready = 1'b0;
    acc(1, 17'h10024, 8'hC1);
    chk("R8 valid while stalled", s_outv, 1);
    acc(0, 17'h10040, 0); chk("R8 stall keeps pending", s_rd, 8'h80);
    out_ready = 1'b1;
    acc(1, 17'h10024, 8'hC1);
    chk("R8 out_data", s_odata, 8'hC1); chk("R9 no early done", s_done, 0);
    acc(1, 17'h10025, 8'hD2);
    chk("R8 out_data2", s_odata, 8'hD2); chk("R9 write done", s_done, 1);
    acc(1, 17'h10026, 8'hE3);
    chk("R10 no valid after end", s_outv, 0);
    out_ready = 1'b0;
  endtask

  task automatic t_zero_restart;
    start(1, 0);
    acc(0, 17'h10040, 0); chk("R6 zero no pending", s_rd, 0);
    in_valid = 1'b1; in_data = 8'h44;
    acc(0, 17'h10020, 0);
    chk("R6 zero read", s_rd, 0); chk("R6 zero no done", s_done, 0);
    start(1, 2);
    acc(0, 17'h10020, 0);
    start(1, 1);
    acc(0, 17'h10040, 0); chk("R6 restart pending", s_rd, 8'h80);
    acc(0, 17'h10020, 0); chk("R6 restart done", s_done, 1);
    in_valid = 1'b0;
  endtask

  task automatic t_reset_again;
    board_irq_set = 1'b1;
    @(negedge clk); board_irq_set = 1'b0;
    start(1, 5);
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
    chk("R12 dma cleared", dma_enable, 0);
    chk("R12 ctrl cleared", ctrl_byte, 0);
    acc(0, 17'h10040, 0); chk("R12 flags cleared", s_rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_chip();
    t_ctrl();
    t_irq();
    t_read_xfer();
    t_write_xfer();
    t_zero_restart();
    t_reset_again();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule